// File: doc/BRIEF.md
# Grouped Compare Shadow Latch Loader

This block sits between the compare registers that software writes and the comparators of a timer. Each of the seven channels holds a written compare value in a holding stage. The value moves into an active latch, the copy that the comparator uses, only when that channel's load condition is met. The load condition can be the write itself, the counter reaching zero, the counter reaching its period value, or a mode-dependent mix of the two.

A 2-bit grouping code binds channels into sets that update atomically. Each set has a leader channel, and that leader's load-condition field decides when the whole set loads. The sets are: every channel alone, pairs, two triples, or all seven channels as one set. A set loads only after every member has been written since the set last loaded, so a comparator never sees one new member value next to a stale one.

The grouping code sits in a register of its own with a write strobe. The timer supplies the zero and period events and a flag for up/down counting.

Top module: `gsl_loader`

## Requirements
- R1: After a synchronous reset every active latch reads zero and the grouping code is 00. With code 00, a channel whose load condition is 00 loads alone on its own write.
- R2: Load condition 00 makes a complete group load at the clock edge that captures its completing write. The written value is visible on the output after that edge.
- R3: Load condition 01 loads a complete group only on a cycle with the zero event. A write alone, or a period event alone, leaves the active value unchanged.
- R4: Load condition 10 loads on the zero event in any mode. It also loads on the period event, but only while the up/down flag is 1.
- R5: Load condition 11 loads a complete group only on a cycle with the period event. The zero event has no effect.
- R6: With grouping code 01, channels {1,2}, {3,4} and {5,6} form pairs led by channels 1, 3 and 5. The leader's load condition governs the pair, and the load-condition fields of channels 2, 4 and 6 are ignored.
- R7: With grouping code 10, channels {1,2,3} and {4,5,6} form triples led by channels 1 and 4.
- R8: With grouping code 11, all seven channels, including channel 0, form one group led by channel 1.
- R9: A group loads only when every member has been written since the group last loaded. Until then every member keeps its previous active value.
- R10: With grouping codes 01 and 10, channel 0 loads on its own, under its own load condition.
- R11: A write that lands in the same cycle as a matching event counts toward completeness, and that newly written value is the one loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_we | input | N | Per-channel write strobe for the compare value |
| cmp_wdata | input | N*W | Packed written values, channel i in bits i*W +: W |
| load_cond | input | 2*N | Packed per-channel load condition, channel i in bits 2i +: 2 |
| grp_we | input | 1 | Write strobe for the grouping code |
| grp_wdata | input | 2 | New grouping code (00 solo, 01 pairs, 10 triples, 11 all) |
| ud_mode | input | 1 | 1 while the timer counts up/down |
| evt_zero | input | 1 | Counter reached zero this cycle |
| evt_period | input | 1 | Counter reached the period value this cycle |
| latch_out | output | N*W | Packed active latch values, channel i in bits i*W +: W |

## Verification
Channel 0 is driven through every load condition against every combination of zero event, period event and up/down flag. This separates the four conditions, and it shows that the period event counts under condition 10 only in up/down mode. Grouped patterns write the members of a set in separate cycles, so a partially written set can be told apart from a complete one. They also give non-leader members a condition that would load at once, which tells leader-governed behaviour from per-channel behaviour. A write that coincides with its event shows which value wins, and a full-group pass confirms that channel 0 joins only under code 11.

// File: rtl/gsl_pkg.sv
package gsl_pkg;

  typedef enum logic [1:0] {
    LC_ON_WRITE     = 2'b00,
    LC_AT_ZERO      = 2'b01,
    LC_ZERO_OR_TURN = 2'b10,
    LC_AT_PERIOD    = 2'b11
  } lc_mode_e;

  typedef enum logic [1:0] {
    GRP_SOLO   = 2'b00,
    GRP_PAIR   = 2'b01,
    GRP_TRIPLE = 2'b10,
    GRP_ALL    = 2'b11
  } grp_mode_e;

  // Index of the channel whose load condition governs channel idx.
  function automatic int leader_of(input int idx, input grp_mode_e g);
    case (g)
      GRP_PAIR:   return (idx == 0) ? 0 : ((idx - 1) / 2) * 2 + 1;
      GRP_TRIPLE: return (idx == 0) ? 0 : ((idx - 1) / 3) * 3 + 1;
      GRP_ALL:    return 1;
      default:    return idx;
    endcase
  endfunction

endpackage

// File: rtl/gsl_hold_bank.sv
module gsl_hold_bank #(
  parameter int N = 7,
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N-1:0]   we,
  input  logic [N*W-1:0] wdata,
  input  logic [N-1:0]   consume,
  output logic [N*W-1:0] next_val,
  output logic [N-1:0]   ready
);

  for (genvar g = 0; g < N; g++) begin : g_ch
    logic [W-1:0] held_q;
    logic         pend_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        held_q <= '0;
        pend_q <= 1'b0;
      end else begin
        if (we[g]) held_q <= wdata[g*W +: W];
        pend_q <= ready[g] & ~consume[g];
      end
    end

    assign ready[g]          = pend_q | we[g];
    assign next_val[g*W +: W] = we[g] ? wdata[g*W +: W] : held_q;
  end

endmodule

// File: rtl/gsl_trig_decode.sv
module gsl_trig_decode
  import gsl_pkg::*;
#(
  parameter int N = 7
) (
  input  logic [2*N-1:0] load_cond,
  input  logic           ud_mode,
  input  logic           evt_zero,
  input  logic           evt_period,
  output logic [N-1:0]   trig
);

  for (genvar g = 0; g < N; g++) begin : g_ch
    lc_mode_e mode;
    assign mode = lc_mode_e'(load_cond[2*g +: 2]);

    always_comb begin
      case (mode)
        LC_ON_WRITE:     trig[g] = 1'b1;
        LC_AT_ZERO:      trig[g] = evt_zero;
        LC_ZERO_OR_TURN: trig[g] = evt_zero | (ud_mode & evt_period);
        default:         trig[g] = evt_period;
      endcase
    end
  end

endmodule

// File: rtl/gsl_group_resolve.sv
module gsl_group_resolve
  import gsl_pkg::*;
#(
  parameter int N = 7
) (
  input  grp_mode_e    grp,
  input  logic [N-1:0] trig,
  input  logic [N-1:0] ready,
  output logic [N-1:0] fire
);

  for (genvar gi = 0; gi < N; gi++) begin : g_row
    logic [N-1:0] same_set;
    logic [N-1:0] is_lead;

    for (genvar gj = 0; gj < N; gj++) begin : g_col
      assign same_set[gj] = (leader_of(gi, grp) == leader_of(gj, grp));
      assign is_lead[gj]  = (gj == leader_of(gi, grp));
    end

    assign fire[gi] = (|(is_lead & trig)) & (&(~same_set | ready));
  end

endmodule

// File: rtl/gsl_active_bank.sv
module gsl_active_bank #(
  parameter int N = 7,
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N-1:0]   fire,
  input  logic [N*W-1:0] next_val,
  output logic [N*W-1:0] active
);

  for (genvar g = 0; g < N; g++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst)          active[g*W +: W] <= '0;
      else if (fire[g]) active[g*W +: W] <= next_val[g*W +: W];
    end
  end

endmodule

// File: rtl/gsl_loader.sv
module gsl_loader
  import gsl_pkg::*;
#(
  parameter int N = 7,
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N-1:0]   cmp_we,
  input  logic [N*W-1:0] cmp_wdata,
  input  logic [2*N-1:0] load_cond,
  input  logic           grp_we,
  input  logic [1:0]     grp_wdata,
  input  logic           ud_mode,
  input  logic           evt_zero,
  input  logic           evt_period,
  output logic [N*W-1:0] latch_out
);

  grp_mode_e      grp_q;
  logic [N-1:0]   trig;
  logic [N-1:0]   ready;
  logic [N-1:0]   fire;
  logic [N*W-1:0] next_val;

  always_ff @(posedge clk) begin
    if (rst)         grp_q <= GRP_SOLO;
    else if (grp_we) grp_q <= grp_mode_e'(grp_wdata);
  end

  gsl_hold_bank #(.N(N), .W(W)) u_hold (
    .clk(clk), .rst(rst), .we(cmp_we), .wdata(cmp_wdata),
    .consume(fire), .next_val(next_val), .ready(ready)
  );

  gsl_trig_decode #(.N(N)) u_trig (
    .load_cond(load_cond), .ud_mode(ud_mode), .evt_zero(evt_zero),
    .evt_period(evt_period), .trig(trig)
  );

  gsl_group_resolve #(.N(N)) u_resolve (
    .grp(grp_q), .trig(trig), .ready(ready), .fire(fire)
  );

  gsl_active_bank #(.N(N), .W(W)) u_active (
    .clk(clk), .rst(rst), .fire(fire), .next_val(next_val), .active(latch_out)
  );

endmodule

// File: rtl/gsl_loader_chk.sv
module gsl_loader_chk
  import gsl_pkg::*;
#(
  parameter int N = 7,
  parameter int W = 16
) (
  input logic           clk,
  input logic           rst,
  input logic [N-1:0]   cmp_we,
  input logic [W-1:0]   wd0,
  input logic [2*N-1:0] load_cond,
  input logic           evt_zero,
  input logic           evt_period,
  input logic [N*W-1:0] latch_out,
  input grp_mode_e      grp_q,
  input logic [N-1:0]   fire,
  input logic [N-1:0]   ready
);

  logic [N*N-1:0] split;
  for (genvar gi = 0; gi < N; gi++) begin : g_r
    for (genvar gj = 0; gj < N; gj++) begin : g_c
      assign split[gi*N+gj] = (gj == leader_of(gi, grp_q)) && (fire[gi] != fire[gj]);
    end
  end

  // R1: reset clears latches and grouping code
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (latch_out == '0 && grp_q == GRP_SOLO));

  // R2: immediate condition on a solo channel 0 loads the written value
  p_immediate_load_r2: assert property (@(posedge clk) disable iff (rst)
    (grp_q == GRP_SOLO && cmp_we[0] && load_cond[1:0] == 2'b00)
      |=> latch_out[W-1:0] == $past(wd0));

  // R3: with no write, no event and stable settings nothing loads
  p_quiet_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (cmp_we == '0 && !evt_zero && !evt_period && $stable(load_cond) && $stable(grp_q))
      |=> $stable(latch_out));

  // R6 (also R7, R8): every member fires together with its leader
  p_group_atomic_r6: assert property (@(posedge clk) disable iff (rst)
    split == '0);

  // R9: a channel fires only when written since its last load
  p_fire_needs_write_r9: assert property (@(posedge clk) disable iff (rst)
    (fire & ~ready) == '0);

endmodule

bind gsl_loader gsl_loader_chk #(.N(N), .W(W)) u_chk (
  .clk(clk), .rst(rst), .cmp_we(cmp_we), .wd0(cmp_wdata[W-1:0]),
  .load_cond(load_cond), .evt_zero(evt_zero), .evt_period(evt_period),
  .latch_out(latch_out), .grp_q(grp_q), .fire(fire), .ready(ready)
);

// File: tb/gsl_loader_tb.sv
`timescale 1ns/1ps
module gsl_loader_tb_top;
  localparam int N = 7;
  localparam int W = 16;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [N-1:0]   cmp_we = '0;
  logic [N*W-1:0] cmp_wdata = '0;
  logic [2*N-1:0] load_cond = '0;
  logic           grp_we = 1'b0;
  logic [1:0]     grp_wdata = 2'b00;
  logic           ud_mode = 1'b0;
  logic           evt_zero = 1'b0;
  logic           evt_period = 1'b0;
  logic [N*W-1:0] latch_out;

  int nchk = 0;
  int nfail = 0;

  always #10 clk = ~clk;

  gsl_loader #(.N(N), .W(W)) dut_i (
    .clk(clk), .rst(rst), .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
    .load_cond(load_cond), .grp_we(grp_we), .grp_wdata(grp_wdata),
    .ud_mode(ud_mode), .evt_zero(evt_zero), .evt_period(evt_period),
    .latch_out(latch_out)
  );

  typedef struct packed {
    logic [1:0] cond;
    logic       ud;
    logic       ez;
    logic       ep;
    logic       exp_load;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{2'd0, 1'b0, 1'b0, 1'b0, 1'b1},
    '{2'd1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{2'd1, 1'b0, 1'b1, 1'b0, 1'b1},
    '{2'd1, 1'b0, 1'b0, 1'b1, 1'b0},
    '{2'd2, 1'b0, 1'b1, 1'b0, 1'b1},
    '{2'd2, 1'b0, 1'b0, 1'b1, 1'b0},
    '{2'd2, 1'b1, 1'b0, 1'b1, 1'b1},
    '{2'd2, 1'b1, 1'b1, 1'b0, 1'b1},
    '{2'd3, 1'b0, 1'b0, 1'b1, 1'b1},
    '{2'd3, 1'b0, 1'b1, 1'b0, 1'b0},
    '{2'd3, 1'b1, 1'b1, 1'b0, 1'b0},
    '{2'd3, 1'b1, 1'b0, 1'b1, 1'b1}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    cmp_we     = '0;
    evt_zero   = 1'b0;
    evt_period = 1'b0;
    grp_we     = 1'b0;
  endtask

  task automatic wr(input int ch, input logic [W-1:0] v);
    cmp_we[ch] = 1'b1;
    cmp_wdata[ch*W +: W] = v;
  endtask

  task automatic set_grp(input logic [1:0] g);
    grp_we = 1'b1;
    grp_wdata = g;
    tick();
  endtask

  task automatic chk(input string tag, input int ch, input logic [W-1:0] exp);
    logic [W-1:0] got;
    got = latch_out[ch*W +: W];
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s ch%0d got %h expected %h", tag, ch, got, exp);
    end
  endtask

  function automatic string cond_tag(input logic [1:0] c);
    case (c)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [W-1:0] prev0;
    @(negedge clk);
    tick(); tick(); tick();
    rst = 1'b0;

    // R1: reset state
    for (int c = 0; c < N; c++) chk("R1", c, '0);
    // R1: grouping code 00 after reset, channel 2 loads alone
    wr(2, 16'h2222); tick();
    chk("R1", 2, 16'h2222);
    chk("R1", 1, 16'h0000);

    // Table walk on channel 0, solo grouping
    prev0 = 16'h0000;
    for (int i = 0; i < 12; i++) begin
      logic [W-1:0] v;
      v = 16'h1000 + 16'(i) * 16'h0111;
      load_cond[1:0] = VECS[i].cond;
      wr(0, v); tick();
      chk(cond_tag(VECS[i].cond), 0, (VECS[i].cond == 2'd0) ? v : prev0);
      ud_mode = VECS[i].ud;
      evt_zero = VECS[i].ez;
      evt_period = VECS[i].ep;
      tick();
      if (VECS[i].exp_load) prev0 = v;
      chk(cond_tag(VECS[i].cond), 0, prev0);
      ud_mode = 1'b0;
    end

    // R6: pairs, leader 1 on period, channel 2 immediate field ignored
    set_grp(2'b01);
    load_cond = {N{2'b11}};
    load_cond[5:4] = 2'b00;
    wr(2, 16'hA002); tick();
    chk("R6", 2, 16'h2222);
    wr(1, 16'hA001); tick();
    chk("R9", 1, 16'h0000);
    evt_period = 1'b1; tick();
    chk("R6", 1, 16'hA001);
    chk("R6", 2, 16'hA002);
    chk("R6", 3, 16'h0000);

    // R10: channel 0 stays independent under pairs
    load_cond[1:0] = 2'b00;
    wr(0, 16'hB000); tick();
    chk("R10", 0, 16'hB000);

    // R7: triples, leader 4 on zero event
    set_grp(2'b10);
    load_cond = {N{2'b11}};
    load_cond[9:8] = 2'b01;
    wr(4, 16'hD004); wr(5, 16'hD005); tick();
    evt_zero = 1'b1; tick();
    chk("R9", 4, 16'h0000);
    chk("R9", 5, 16'h0000);
    wr(6, 16'hD006); tick();
    evt_zero = 1'b1; tick();
    chk("R7", 4, 16'hD004);
    chk("R7", 5, 16'hD005);
    chk("R7", 6, 16'hD006);

    // R8: all channels one group, leader 1 immediate, channel 0 on period
    set_grp(2'b11);
    load_cond = {N{2'b11}};
    load_cond[3:2] = 2'b00;
    for (int c = 0; c < 6; c++) wr(c, 16'hC000 + 16'(c));
    tick();
    chk("R9", 0, 16'hB000);
    chk("R9", 5, 16'hD005);
    wr(6, 16'hC006); tick();
    for (int c = 0; c < N; c++) chk("R8", c, 16'hC000 + 16'(c));

    // R11: write coinciding with the zero event loads the new value
    set_grp(2'b00);
    load_cond = {N{2'b11}};
    load_cond[7:6] = 2'b01;
    wr(3, 16'hE003); evt_zero = 1'b1; tick();
    chk("R11", 3, 16'hE003);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule